// File: doc/BRIEF.md
# Address Window Translation Register Bank

This block keeps a set of programmable address windows and uses them to send outgoing memory-mapped requests to a RapidIO target. Software programs each window through a 32-bit register port. A window has four word registers: a base, a mask carrying the enable bit, a 34-bit target offset, and a control word. The control word holds the destination ID, the request priority, the critical-flow flag and the write flavour.

On the lookup side, a request address is compared with every enabled window at once. The lowest-numbered window that matches sets the outputs: a 34-bit translated address, the destination ID, the priority, the critical-flow bit and a write-type code. A miss flag is raised when no window matches. The register port applies two write rules. An illegal priority value is replaced by a legal one. A write that would set both write-type enables at once leaves that pair of bits unchanged.

Top module: `awt_xlate_bank`

## Requirements
- R1: After reset every window is disabled and all of its register fields read as zero, so every lookup misses.
- R2: Window n is decoded at byte address REG_BASE + 16*n (default 0x10400). Its base, mask, offset and control registers sit at +0x0, +0x4, +0x8 and +0xC. A read returns its data with `cfg_rvalid` high exactly one cycle after the read is accepted, and `cfg_rvalid` is low in every other cycle.
- R3: Reserved bits read as zero. In the base register these are bits [3:0]. In the mask register they are bits 3, 1 and 0, and bit 2 is the window enable. In the offset register they are bits [3:2], with bits [1:0] holding translated address bits [33:32]. In the control register they are bits [15:8] and [5:3], with bits [23:16] holding the destination ID low byte, [7:6] the priority, bit 2 the critical-flow flag, bit 1 the streaming-write enable and bit 0 the write-with-response enable.
- R4: A write changes only the byte lanes whose `cfg_be` bit is set (bit k covers data bits [8k+7:8k]).
- R5: Writing priority 2'b11 stores 2'b10. Every other priority value is stored unchanged.
- R6: A control write that would leave both bit 1 and bit 0 set keeps those two bits at their previous values. The other fields of that write are still stored.
- R7: Control bits [31:24] (destination ID high byte) are writable only when WIDE_ID is 1. Otherwise they read as zero and `lk_dest_id[15:8]` stays zero.
- R8: An address hits window n when that window is enabled and (addr & mask) equals (base & mask), using 32-bit base and mask values whose low four bits are zero.
- R9: When several windows hit, the lowest-numbered one supplies the outputs.
- R10: On a hit, `lk_xaddr` = {offset[33:32], offset[31:4], 4'b0} + (addr & ~mask), computed over 34 bits. `lk_wtype` is 2 if the streaming-write enable is set, 1 if the write-with-response enable is set, and 0 otherwise. Destination ID, priority and critical-flow outputs come from the control register.
- R11: One cycle after each cycle with `lk_valid` high, `lk_out_valid` is high and exactly one of `lk_hit` and `lk_miss` is set. After a cycle with `lk_valid` low, `lk_out_valid` is low.
- R12: Accesses whose address is outside the bank, or whose bits [1:0] are not zero, read as zero and change nothing.
- R13: A lookup issued in the same cycle as a window write uses the old window settings. A lookup issued in the following cycle uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 32 | Register byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the read |
| cfg_rdata | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Memory-mapped request address |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Some window matched |
| lk_miss | output | 1 | No window matched |
| lk_xaddr | output | 34 | Translated RapidIO address |
| lk_dest_id | output | 16 | Destination ID |
| lk_prio | output | 2 | Request priority |
| lk_crf | output | 1 | Critical request flow flag |
| lk_wtype | output | 2 | 0 plain write, 1 write with response, 2 streaming write |

## Verification
The bench targets the write rules. It writes priority 2'b11 and expects 2'b10; a design without the coercion would store an illegal priority. It sets both write-type enables in a write that also changes other fields; a design that dropped the whole word, or accepted both bits, would read back wrong. Overlapping windows check that the lowest index wins, since a reversed encoder returns the wrong destination. A window is enabled in the same cycle as a lookup to expose an early or late update. Partial byte-enable writes, misaligned and out-of-range addresses, and an offset whose addition carries into bits [33:32] catch merge and adder-width errors.

// File: rtl/awt_pkg.sv
`timescale 1ns/1ps
package awt_pkg;

    localparam int AW = 32;
    localparam int XW = 34;
    localparam int GW = 4;
    localparam int FW = AW - GW;

    typedef enum logic [1:0] {
        WT_NWRITE   = 2'd0,
        WT_NWRITE_R = 2'd1,
        WT_SWRITE   = 2'd2
    } wtype_e;

    typedef struct packed {
        logic [FW-1:0] base;
        logic [FW-1:0] mask;
        logic          en;
        logic [FW-1:0] offs;
        logic [1:0]    xhi;
        logic [7:0]    did_hi;
        logic [7:0]    did_lo;
        logic [1:0]    prio;
        logic          crf;
        logic          sw_en;
        logic          nwr_en;
    } win_regs_t;

    typedef struct packed {
        logic          rvalid;
        logic [31:0]   rdata;
        logic          ovalid;
        logic          ohit;
        logic [XW-1:0] oaddr;
        logic [15:0]   odid;
        logic [1:0]    oprio;
        logic          ocrf;
        wtype_e        owtype;
    } bank_out_t;

    function automatic logic [31:0] reg_view(input win_regs_t r, input logic [1:0] sel);
        case (sel)
            2'd0:    reg_view = {r.base, 4'h0};
            2'd1:    reg_view = {r.mask, 1'b0, r.en, 2'b00};
            2'd2:    reg_view = {r.offs, 2'b00, r.xhi};
            default: reg_view = {r.did_hi, r.did_lo, 8'h00, r.prio, 3'b000,
                                 r.crf, r.sw_en, r.nwr_en};
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        for (int k = 0; k < 4; k++) lane_mask[8*k +: 8] = {8{be[k]}};
    endfunction

endpackage

// File: rtl/awt_window.sv
`timescale 1ns/1ps
module awt_window
    import awt_pkg::*;
#(
    parameter bit WIDE_ID = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [31:0]    wr_data,
    input  logic [3:0]     wr_be,
    input  logic [1:0]     rd_sel,
    output logic [31:0]    rd_data,
    input  logic [AW-1:0]  lk_addr,
    output logic           hit,
    output logic [XW-1:0]  xaddr,
    output logic [15:0]    dest_id,
    output logic [1:0]     prio,
    output logic           crf,
    output wtype_e         wtype
);

    win_regs_t   win_d, win_q;
    logic [31:0] merged;

    always_comb begin
        win_d  = win_q;
        merged = (reg_view(win_q, wr_sel) & ~lane_mask(wr_be)) | (wr_data & lane_mask(wr_be));
        if (wr_en) begin
            case (wr_sel)
                2'd0: win_d.base = merged[31:GW];
                2'd1: begin
                    win_d.mask = merged[31:GW];
                    win_d.en   = merged[2];
                end
                2'd2: begin
                    win_d.offs = merged[31:GW];
                    win_d.xhi  = merged[1:0];
                end
                default: begin
                    win_d.did_hi = WIDE_ID ? merged[31:24] : 8'h00;
                    win_d.did_lo = merged[23:16];
                    win_d.prio   = (merged[7:6] == 2'b11) ? 2'b10 : merged[7:6];
                    win_d.crf    = merged[2];
                    if (!(merged[1] && merged[0])) begin
                        win_d.sw_en  = merged[1];
                        win_d.nwr_en = merged[0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    always_comb begin
        rd_data = reg_view(win_q, rd_sel);
        hit     = win_q.en &&
                  (((lk_addr ^ {win_q.base, 4'h0}) & {win_q.mask, 4'h0}) == '0);
        xaddr   = {win_q.xhi, win_q.offs, 4'h0} +
                  {2'b00, lk_addr & ~{win_q.mask, 4'h0}};
        dest_id = {win_q.did_hi, win_q.did_lo};
        prio    = win_q.prio;
        crf     = win_q.crf;
        if (win_q.sw_en)       wtype = WT_SWRITE;
        else if (win_q.nwr_en) wtype = WT_NWRITE_R;
        else                   wtype = WT_NWRITE;
    end

    p_prio_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.prio != 2'b11);

    p_pair_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && wr_be[0] && wr_data[1:0] == 2'b11)
        |=> $stable({win_q.sw_en, win_q.nwr_en}));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(win_q));

endmodule

// File: rtl/awt_pick.sv
`timescale 1ns/1ps
module awt_pick #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/awt_xlate_bank.sv
`timescale 1ns/1ps
module awt_xlate_bank
    import awt_pkg::*;
#(
    parameter int          NUM_WIN  = 16,
    parameter logic [31:0] REG_BASE = 32'h0001_0400,
    parameter bit          WIDE_ID  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_valid,
    input  logic        cfg_write,
    input  logic [31:0] cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  cfg_be,
    output logic        cfg_rvalid,
    output logic [31:0] cfg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    output logic        lk_out_valid,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [33:0] lk_xaddr,
    output logic [15:0] lk_dest_id,
    output logic [1:0]  lk_prio,
    output logic        lk_crf,
    output logic [1:0]  lk_wtype
);

    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic         in_bank;
    logic         slot_ok;
    logic [3:0]   win_idx;
    logic [1:0]   reg_sel;

    logic [NUM_WIN-1:0] w_hit;
    logic [31:0]        w_rd   [NUM_WIN];
    logic [XW-1:0]      w_xa   [NUM_WIN];
    logic [15:0]        w_did  [NUM_WIN];
    logic [1:0]         w_prio [NUM_WIN];
    logic               w_crf  [NUM_WIN];
    wtype_e             w_wt   [NUM_WIN];

    logic [IW-1:0] pick_idx;
    logic          pick_any;

    bank_out_t out_d, out_q;

    assign in_bank = (cfg_addr[31:8] == REG_BASE[31:8]);
    assign win_idx = cfg_addr[7:4];
    assign reg_sel = cfg_addr[3:2];
    assign slot_ok = in_bank && (cfg_addr[1:0] == 2'b00) && ({28'h0, win_idx} < NUM_WIN);

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        awt_window #(.WIDE_ID(WIDE_ID)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_valid && cfg_write && slot_ok && (win_idx == 4'(n))),
            .wr_sel  (reg_sel),
            .wr_data (cfg_wdata),
            .wr_be   (cfg_be),
            .rd_sel  (reg_sel),
            .rd_data (w_rd[n]),
            .lk_addr (lk_addr),
            .hit     (w_hit[n]),
            .xaddr   (w_xa[n]),
            .dest_id (w_did[n]),
            .prio    (w_prio[n]),
            .crf     (w_crf[n]),
            .wtype   (w_wt[n])
        );
    end

    awt_pick #(.N(NUM_WIN)) u_pick (
        .req (w_hit),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        out_d        = '0;
        out_d.rvalid = cfg_valid && !cfg_write;
        for (int n = 0; n < NUM_WIN; n++) begin
            if (slot_ok && (win_idx == 4'(n)) && out_d.rvalid) out_d.rdata = w_rd[n];
        end
        out_d.ovalid = lk_valid;
        if (lk_valid && pick_any) begin
            out_d.ohit   = 1'b1;
            out_d.oaddr  = w_xa[pick_idx];
            out_d.odid   = w_did[pick_idx];
            out_d.oprio  = w_prio[pick_idx];
            out_d.ocrf   = w_crf[pick_idx];
            out_d.owtype = w_wt[pick_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cfg_rvalid   = out_q.rvalid;
    assign cfg_rdata    = out_q.rdata;
    assign lk_out_valid = out_q.ovalid;
    assign lk_hit       = out_q.ohit;
    assign lk_miss      = out_q.ovalid && !out_q.ohit;
    assign lk_xaddr     = out_q.oaddr;
    assign lk_dest_id   = out_q.odid;
    assign lk_prio      = out_q.oprio;
    assign lk_crf       = out_q.ocrf;
    assign lk_wtype     = out_q.owtype;

    p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write) |=> cfg_rvalid);

    p_no_stray_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && !cfg_write) |=> !cfg_rvalid);

    p_lk_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_out_valid);

    p_lk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_out_valid);

    p_outside_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write && !in_bank) |=> (cfg_rdata == 32'h0));

    p_wtype_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_wtype != 2'b11));

endmodule

// File: tb/sim_awt_xlate_bank.sv
`timescale 1ns/1ps
module sim_awt_xlate_bank;

    localparam int NW   = 16;
    localparam bit WIDE = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [31:0] cfg_addr = '0, cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_out_valid, lk_hit, lk_miss, lk_crf;
    logic [33:0] lk_xaddr;
    logic [15:0] lk_dest_id;
    logic [1:0]  lk_prio, lk_wtype;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    awt_xlate_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_out_valid(lk_out_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_xaddr(lk_xaddr), .lk_dest_id(lk_dest_id), .lk_prio(lk_prio),
        .lk_crf(lk_crf), .lk_wtype(lk_wtype)
    );

    // behavioural model state
    logic [27:0] m_base [NW];
    logic [27:0] m_mask [NW];
    logic [27:0] m_off  [NW];
    logic        m_en   [NW];
    logic [1:0]  m_xhi  [NW];
    logic [7:0]  m_dhi  [NW];
    logic [7:0]  m_dlo  [NW];
    logic [1:0]  m_prio [NW];
    logic        m_crf  [NW];
    logic        m_sw   [NW];
    logic        m_nw   [NW];

    logic        e_rvalid = 1'b0, e_ovalid = 1'b0, e_hit = 1'b0;
    logic [31:0] e_rdata = '0;
    logic [33:0] e_xaddr = '0;
    logic [15:0] e_did = '0;
    logic [1:0]  e_prio = '0, e_wtype = '0;
    logic        e_crf = 1'b0;

    function automatic int slot_of(input logic [31:0] a);
        if (a[31:8] != 24'h000104 || a[1:0] != 2'b00) return -1;
        return int'(a[7:4]);
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] a);
        int n;
        n = slot_of(a);
        if (n < 0) return 32'h0;
        case (a[3:2])
            2'd0:    return {m_base[n], 4'h0};
            2'd1:    return {m_mask[n], 1'b0, m_en[n], 2'b00};
            2'd2:    return {m_off[n], 2'b00, m_xhi[n]};
            default: return {m_dhi[n], m_dlo[n], 8'h00, m_prio[n], 3'b000,
                             m_crf[n], m_sw[n], m_nw[n]};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NW; n++) begin
                m_base[n] = '0; m_mask[n] = '0; m_off[n] = '0; m_en[n] = 1'b0;
                m_xhi[n] = '0; m_dhi[n] = '0; m_dlo[n] = '0; m_prio[n] = '0;
                m_crf[n] = 1'b0; m_sw[n] = 1'b0; m_nw[n] = 1'b0;
            end
            e_rvalid = 1'b0; e_ovalid = 1'b0; e_hit = 1'b0; e_rdata = '0;
        end else begin
            // results of this edge use the state before any write (R13)
            e_rvalid = cfg_valid && !cfg_write;
            e_rdata  = e_rvalid ? m_read(cfg_addr) : 32'h0;
            e_ovalid = lk_valid;
            e_hit    = 1'b0;
            if (lk_valid) begin
                int w;
                w = -1;
                for (int n = 0; n < NW; n++)
                    if (w < 0 && m_en[n] &&
                        (((lk_addr ^ {m_base[n], 4'h0}) & {m_mask[n], 4'h0}) == 32'h0))
                        w = n;
                if (w >= 0) begin
                    e_hit   = 1'b1;
                    e_xaddr = {m_xhi[w], m_off[w], 4'h0} + {2'b00, lk_addr & ~{m_mask[w], 4'h0}};
                    e_did   = {m_dhi[w], m_dlo[w]};
                    e_prio  = m_prio[w];
                    e_crf   = m_crf[w];
                    e_wtype = m_sw[w] ? 2'd2 : (m_nw[w] ? 2'd1 : 2'd0);
                end
            end
            if (cfg_valid && cfg_write && slot_of(cfg_addr) >= 0) begin
                int n;
                logic [31:0] bm, v;
                n = slot_of(cfg_addr);
                bm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
                v  = (m_read(cfg_addr) & ~bm) | (cfg_wdata & bm);
                case (cfg_addr[3:2])
                    2'd0: m_base[n] = v[31:4];
                    2'd1: begin m_mask[n] = v[31:4]; m_en[n] = v[2]; end
                    2'd2: begin m_off[n] = v[31:4]; m_xhi[n] = v[1:0]; end
                    default: begin
                        if (WIDE) m_dhi[n] = v[31:24];
                        m_dlo[n]  = v[23:16];
                        m_prio[n] = (v[7:6] == 2'b11) ? 2'b10 : v[7:6];
                        m_crf[n]  = v[2];
                        if (v[1:0] != 2'b11) begin m_sw[n] = v[1]; m_nw[n] = v[0]; end
                    end
                endcase
            end
        end
    end

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cfg_rvalid == e_rvalid, "rvalid", 64'(cfg_rvalid), 64'(e_rvalid));
            if (e_rvalid) chk(cfg_rdata == e_rdata, "rdata", 64'(cfg_rdata), 64'(e_rdata));
            chk(lk_out_valid == e_ovalid, "lk_out_valid", 64'(lk_out_valid), 64'(e_ovalid));
            if (e_ovalid) begin
                chk(lk_hit == e_hit && lk_miss == !e_hit, "hit/miss",
                    64'({lk_hit, lk_miss}), 64'({e_hit, !e_hit}));
                if (e_hit) begin
                    chk(lk_xaddr == e_xaddr, "xaddr", 64'(lk_xaddr), 64'(e_xaddr));
                    chk(lk_dest_id == e_did, "dest_id", 64'(lk_dest_id), 64'(e_did));
                    chk(lk_prio == e_prio, "prio", 64'(lk_prio), 64'(e_prio));
                    chk(lk_crf == e_crf, "crf", 64'(lk_crf), 64'(e_crf));
                    chk(lk_wtype == e_wtype, "wtype", 64'(lk_wtype), 64'(e_wtype));
                end
            end
        end
    end

    function automatic logic [31:0] wa(input int n, input int r);
        return 32'h0001_0400 + 32'(n * 16 + r * 4);
    endfunction

    // each task starts just after a falling edge and ends on the next one
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic lk(input logic [31:0] a);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic wr_lk(input logic [31:0] a, input logic [31:0] d, input logic [31:0] la);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = 4'hF;
        lk_valid = 1'b1; lk_addr = la;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0; lk_valid = 1'b0;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (%s)", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        rd(wa(0, 0)); rd(wa(15, 3)); rd(wa(7, 1));
        lk(32'h1234_5678); lk(32'h0000_0000);

        cur_req = "R2";
        wr(wa(3, 0), 32'hFFFF_FFFF, 4'hF); rd(wa(3, 0));
        wr(wa(9, 2), 32'h0BAD_F00D, 4'hF); rd(wa(9, 2)); rd(wa(8, 2));

        cur_req = "R3";
        wr(wa(3, 1), 32'hFFFF_FFFF, 4'hF); rd(wa(3, 1));
        wr(wa(3, 2), 32'hFFFF_FFFF, 4'hF); rd(wa(3, 2));
        wr(wa(3, 3), 32'hFFFF_FF3C, 4'hF); rd(wa(3, 3));

        cur_req = "R4";
        wr(wa(4, 0), 32'hAABB_CCDD, 4'b0100); rd(wa(4, 0));
        wr(wa(4, 2), 32'h1122_3347, 4'b0001); rd(wa(4, 2));
        wr(wa(4, 3), 32'h0077_00C3, 4'b0010); rd(wa(4, 3));

        cur_req = "R5";
        wr(wa(6, 3), 32'h0000_00C0, 4'hF); rd(wa(6, 3));
        wr(wa(6, 3), 32'h0000_0040, 4'hF); rd(wa(6, 3));

        cur_req = "R6";
        wr(wa(6, 3), 32'h0000_0002, 4'hF); rd(wa(6, 3));
        wr(wa(6, 3), 32'h00AA_0047, 4'hF); rd(wa(6, 3));
        wr(wa(6, 3), 32'h0000_0001, 4'hF); rd(wa(6, 3));

        cur_req = "R7";
        wr(wa(6, 3), 32'hFF00_0000, 4'b1000); rd(wa(6, 3));

        cur_req = "R8";
        wr(wa(0, 0), 32'h8000_0000, 4'hF);
        wr(wa(0, 1), 32'hF000_0004, 4'hF);
        lk(32'h8123_4567); lk(32'h9000_0000); lk(32'hFFFF_FFF3);
        wr(wa(1, 1), 32'h0000_0000, 4'hF); lk(32'h0000_1000);

        cur_req = "R9";
        wr(wa(5, 0), 32'h4000_0000, 4'hF); wr(wa(5, 1), 32'hC000_0004, 4'hF);
        wr(wa(5, 3), 32'h0055_0001, 4'hF);
        wr(wa(2, 0), 32'h4100_0000, 4'hF); wr(wa(2, 1), 32'hFF00_0004, 4'hF);
        lk(32'h41AB_CDEF); lk(32'h4200_0000); lk(32'h7FFF_FFFF);

        cur_req = "R10";
        wr(wa(2, 2), 32'h1234_5672, 4'hF); wr(wa(2, 3), 32'h0033_0086, 4'hF);
        lk(32'h41AB_CDEF);
        wr(wa(5, 2), 32'hFFFF_FFF1, 4'hF); lk(32'h7FFF_FFFF); lk(32'h4000_0003);

        cur_req = "R11";
        lk(32'h8000_0000); lk(32'h0000_0040); lk(32'h4100_0000);

        cur_req = "R12";
        wr(32'h0001_0300, 32'hFFFF_FFFF, 4'hF); rd(32'h0001_0300);
        wr(32'h0002_0404, 32'hFFFF_FFFF, 4'hF); rd(32'h0002_0404);
        wr(wa(0, 1) + 32'd1, 32'h0000_0000, 4'hF); rd(wa(0, 1) + 32'd1);
        rd(wa(0, 1)); lk(32'h8000_0010);

        cur_req = "R13";
        wr(wa(7, 0), 32'h2000_0000, 4'hF);
        wr_lk(wa(7, 1), 32'hFFFF_0004, 32'h2000_0010);
        lk(32'h2000_0010);
        wr_lk(wa(7, 1), 32'h0000_0000, 32'h2000_0020);
        lk(32'h2000_0020);

        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            cfg_valid = r[0];
            cfg_write = r[1];
            cfg_addr  = r[2] ? wa(int'(r[7:4]), int'(r[9:8])) : {$urandom} & 32'h0003_07FF;
            cfg_wdata = (r[10] && r[9:8] == 2'd1) ? ({$urandom} | 32'h4) & 32'hF000_000F | 32'h4
                                                  : $urandom;
            cfg_be    = r[11] ? 4'hF : r[15:12];
            lk_valid  = r[16];
            lk_addr   = {r[23:20], 28'(($urandom) & 32'h0FFF_FFFF)};
            @(negedge clk);
        end
        cfg_valid = 1'b0; lk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule